// File: doc/BRIEF.md
# Seven-Channel Legacy DMA Controller

This block moves data between peripherals and memory on behalf of up to seven requesters. Software programs each channel through a small register port: a start address, a transfer count, a high-address (page) byte, a mode and a mask. When an unmasked channel raises its request line, the controller asks for the bus, waits for the grant and then runs one or more transfers. During each transfer it drives a byte address, an acknowledge line for the serviced channel and a memory read or write strobe. A size flag tells the system whether the transfer is a byte or a 16-bit word.

There are eight channel slots. Slots 0 to 3 move bytes. Slots 5 to 7 move 16-bit words, and their programmed address counts words. Slot 4 moves no data: it stands for the cascade and bus-master request path. It has no registers, and its request line is never granted.

A channel can hand the bus back after every transfer, or keep it for as long as its request stays high. A verify channel walks its address and count without strobing memory. A channel whose count runs out either reloads its start values or masks itself. Up to two channels may use a shortened transfer timing.

Top module: `dma7_ctrl`

## Requirements
- R1: After reset every channel is masked (ctrl field bit 0 = 1) and its status bit is clear (ctrl bit 1 = 0). All address, count, page and mode fields read 0, `hold_req_o` is low and `dack_o` is 0.
- R2: Register address bits [5:3] select the channel slot and bits [2:0] select the field.
  - Field codes: 0 = start address, 1 = start count, 2 = current address, 3 = current count, 4 = mode, 5 = page, 6 = ctrl.
  - Writing field 0 or field 1 loads both the start value and the current value. Writing field 2 or field 3 loads only the current value.
  - Every field reads back the value it holds. Slot 4 ignores writes and reads as 0.
- R3: Requests from unmasked channels are granted in fixed priority, and the lowest channel number wins.
- R4: On channels 0 to 3, `bus_addr_o` is {page, current address} and `word_o` is 0. The address rises by 1 per transfer.
- R5: On channels 5 to 7, `bus_addr_o` is {page[6:0], current address, 1'b0} and `word_o` is 1. The word address rises by 1 per transfer.
- R6: A programmed count N gives N+1 transfers. `tc_o` pulses on the last transfer, when the current count steps from 0 to all ones, and the channel's status bit (ctrl bit 1) is set.
- R7: At terminal count, a channel with auto-reload set (mode bit 3) copies its start address and start count back into the current registers. A channel without it sets its mask bit.
- R8: In single mode (mode bit 2 = 0), `hold_req_o` drops after every transfer.
- R9: In demand mode (mode bit 2 = 1), transfers continue back to back while the request stays high, and the bus is released when the request falls or the count ends.
- R10: Mode bits [1:0] select the transfer kind: 01 writes memory (`mem_wr_o`) and 10 reads memory (`mem_rd_o`). Kinds 00 and 11 verify: they step the address and count but raise no strobe.
- R11: With normal timing, each transfer is one address cycle followed by one strobe cycle. With fast timing (mode bit 4), each transfer is a single strobe cycle.
- R12: At most two channels hold the fast bit. A mode write that would set it on a third channel stores fast = 0.
- R13: The request on slot 4 is never acknowledged and never raises `hold_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 6 | Register address: slot in [5:3], field in [2:0] |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| dreq_i | input | 8 | Per-slot transfer request |
| hold_req_o | output | 1 | Bus request to the system |
| hold_ack_i | input | 1 | Bus grant from the system |
| dack_o | output | 8 | One-hot acknowledge of the serviced slot |
| bus_addr_o | output | 24 | Byte address of the current transfer |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| word_o | output | 1 | 1 for a 16-bit transfer, 0 for a byte |
| tc_o | output | 1 | Terminal-count pulse |

## Verification
The bench aims at the following corner cases, each tied to the fault it would expose:

- **Address wrap on a word channel with auto-reload.** A design that reloads before stepping, or that skips the reload, leaves the wrong current address behind.
- **A count of zero.** A controller that ends on reaching 0 rather than on wrapping past it makes one transfer too few.
- **A third fast channel.** A controller that accepts it changes the mode read-back.
- **Shortened timing.** A wrong cycle sequence shows up directly in the number of acknowledge cycles per transfer.
- **Single versus demand release.** Getting this wrong changes how many times the bus is handed back.
- **A verify channel.** If it strobes, the strobe count is wrong.
- **Two channels raising requests together.** Inverted priority grants the higher-numbered one.
- **A request on slot 4.** If it is granted, `hold_req_o` rises.

// File: rtl/dma7_pkg.sv
package dma7_pkg;

    parameter int ADDR_W = 16;
    parameter int CNT_W  = 16;
    parameter int PAGE_W = 8;
    parameter int DATA_W = 16;

    typedef enum logic [1:0] {
        K_VERIFY = 2'b00,
        K_WRITE  = 2'b01,
        K_READ   = 2'b10,
        K_VERIFY2 = 2'b11
    } kind_e;

    typedef struct packed {
        logic  fast;
        logic  auto_init;
        logic  demand;
        kind_e kind;
    } mode_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base_addr;
        logic [ADDR_W-1:0] cur_addr;
        logic [CNT_W-1:0]  base_cnt;
        logic [CNT_W-1:0]  cur_cnt;
        logic [PAGE_W-1:0] page;
        mode_t             mode;
        logic              mask;
        logic              status;
    } chan_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HOLD = 2'd1,
        S_ADDR = 2'd2,
        S_STRB = 2'd3
    } fsm_e;

    typedef enum logic [2:0] {
        F_BASE_ADDR = 3'd0,
        F_BASE_CNT  = 3'd1,
        F_CUR_ADDR  = 3'd2,
        F_CUR_CNT   = 3'd3,
        F_MODE      = 3'd4,
        F_PAGE      = 3'd5,
        F_CTRL      = 3'd6
    } field_e;

endpackage

// File: rtl/dma7_arbiter.sv
module dma7_arbiter #(
    parameter int NCH   = 8,
    parameter int SKIP  = 4,
    localparam int IDX_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]   req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top down so the lowest eligible slot is the last to claim.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req_i[i] && (i != SKIP)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma7_fast_guard.sv
module dma7_fast_guard #(
    parameter int NCH      = 8,
    parameter int MAX_FAST = 2,
    localparam int IDX_W   = $clog2(NCH)
) (
    input  logic [NCH-1:0]   fast_vec_i,
    input  logic [IDX_W-1:0] sel_i,
    input  logic             want_i,
    output logic             allow_o
);

    logic [NCH-1:0] others;
    int unsigned    n_other;

    always_comb begin
        others = fast_vec_i;
        others[sel_i] = 1'b0;
        n_other = 0;
        for (int i = 0; i < NCH; i++) begin
            n_other = n_other + {31'd0, others[i]};
        end
        allow_o = want_i && (n_other < MAX_FAST);
    end

endmodule

// File: rtl/dma7_ctrl.sv
module dma7_ctrl
    import dma7_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int RSV        = 4,
    parameter int WORD_FIRST = 5,
    parameter int MAX_FAST   = 2,
    localparam int CH_W      = $clog2(NCH),
    localparam int RA_W      = CH_W + 3,
    localparam int BUS_W     = PAGE_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we_i,
    input  logic [RA_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [NCH-1:0]    dreq_i,
    output logic              hold_req_o,
    input  logic              hold_ack_i,
    output logic [NCH-1:0]    dack_o,
    output logic [BUS_W-1:0]  bus_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              word_o,
    output logic              tc_o
);

    typedef struct packed {
        chan_t [NCH-1:0] ch;
        fsm_e            fsm;
        logic [CH_W-1:0] act;
    } state_t;

    state_t st_d, st_q;

    logic [CH_W-1:0] sel_ch;
    field_e          sel_fld;
    logic [NCH-1:0]  mask_vec;
    logic [NCH-1:0]  fast_vec;
    logic            arb_valid;
    logic [CH_W-1:0] arb_idx;
    logic            fast_ok;
    chan_t           cur;
    logic            busy;
    logic            strb;
    logic            is_word;
    logic            at_tc;

    assign sel_ch  = reg_addr_i[RA_W-1:3];
    assign sel_fld = field_e'(reg_addr_i[2:0]);

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            mask_vec[i] = st_q.ch[i].mask;
            fast_vec[i] = st_q.ch[i].mode.fast;
        end
    end

    dma7_arbiter #(.NCH(NCH), .SKIP(RSV)) u_arb (
        .req_i   (dreq_i & ~mask_vec),
        .valid_o (arb_valid),
        .idx_o   (arb_idx)
    );

    dma7_fast_guard #(.NCH(NCH), .MAX_FAST(MAX_FAST)) u_fast (
        .fast_vec_i (fast_vec),
        .sel_i      (sel_ch),
        .want_i     (reg_wdata_i[4]),
        .allow_o    (fast_ok)
    );

    assign cur     = st_q.ch[st_q.act];
    assign busy    = (st_q.fsm == S_ADDR) || (st_q.fsm == S_STRB);
    assign strb    = (st_q.fsm == S_STRB);
    assign is_word = (int'(st_q.act) >= WORD_FIRST);
    assign at_tc   = (cur.cur_cnt == '0);

    // Next-state computation: software writes first, the engine overrides.
    always_comb begin
        st_d = st_q;

        if (reg_we_i && (int'(sel_ch) != RSV)) begin
            case (sel_fld)
                F_BASE_ADDR: begin
                    st_d.ch[sel_ch].base_addr = reg_wdata_i[ADDR_W-1:0];
                    st_d.ch[sel_ch].cur_addr  = reg_wdata_i[ADDR_W-1:0];
                end
                F_BASE_CNT: begin
                    st_d.ch[sel_ch].base_cnt = reg_wdata_i[CNT_W-1:0];
                    st_d.ch[sel_ch].cur_cnt  = reg_wdata_i[CNT_W-1:0];
                end
                F_CUR_ADDR: st_d.ch[sel_ch].cur_addr = reg_wdata_i[ADDR_W-1:0];
                F_CUR_CNT:  st_d.ch[sel_ch].cur_cnt  = reg_wdata_i[CNT_W-1:0];
                F_MODE: begin
                    st_d.ch[sel_ch].mode      = mode_t'(reg_wdata_i[4:0]);
                    st_d.ch[sel_ch].mode.fast = fast_ok;
                end
                F_PAGE: st_d.ch[sel_ch].page = reg_wdata_i[PAGE_W-1:0];
                F_CTRL: begin
                    st_d.ch[sel_ch].mask   = reg_wdata_i[0];
                    st_d.ch[sel_ch].status = reg_wdata_i[1];
                end
                default: ;
            endcase
        end

        case (st_q.fsm)
            S_IDLE: begin
                if (arb_valid) begin
                    st_d.act = arb_idx;
                    st_d.fsm = S_HOLD;
                end
            end
            S_HOLD: begin
                if (hold_ack_i) begin
                    st_d.fsm = cur.mode.fast ? S_STRB : S_ADDR;
                end
            end
            S_ADDR: st_d.fsm = S_STRB;
            S_STRB: begin
                if (at_tc) begin
                    st_d.ch[st_q.act].status = 1'b1;
                    if (cur.mode.auto_init) begin
                        st_d.ch[st_q.act].cur_addr = cur.base_addr;
                        st_d.ch[st_q.act].cur_cnt  = cur.base_cnt;
                    end else begin
                        st_d.ch[st_q.act].cur_addr = cur.cur_addr + 1'b1;
                        st_d.ch[st_q.act].cur_cnt  = cur.cur_cnt - 1'b1;
                        st_d.ch[st_q.act].mask     = 1'b1;
                    end
                    st_d.fsm = S_IDLE;
                end else begin
                    st_d.ch[st_q.act].cur_addr = cur.cur_addr + 1'b1;
                    st_d.ch[st_q.act].cur_cnt  = cur.cur_cnt - 1'b1;
                    if (cur.mode.demand && dreq_i[st_q.act]) begin
                        st_d.fsm = cur.mode.fast ? S_STRB : S_ADDR;
                    end else begin
                        st_d.fsm = S_IDLE;
                    end
                end
            end
            default: st_d.fsm = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NCH; i++) begin
                st_q.ch[i].mask <= 1'b1;
            end
        end else begin
            st_q <= st_d;
        end
    end

    // Register read-back.
    always_comb begin
        reg_rdata_o = '0;
        if (int'(sel_ch) != RSV) begin
            case (sel_fld)
                F_BASE_ADDR: reg_rdata_o = DATA_W'(st_q.ch[sel_ch].base_addr);
                F_BASE_CNT:  reg_rdata_o = DATA_W'(st_q.ch[sel_ch].base_cnt);
                F_CUR_ADDR:  reg_rdata_o = DATA_W'(st_q.ch[sel_ch].cur_addr);
                F_CUR_CNT:   reg_rdata_o = DATA_W'(st_q.ch[sel_ch].cur_cnt);
                F_MODE:      reg_rdata_o = DATA_W'(st_q.ch[sel_ch].mode);
                F_PAGE:      reg_rdata_o = DATA_W'(st_q.ch[sel_ch].page);
                F_CTRL:      reg_rdata_o = DATA_W'({st_q.ch[sel_ch].status,
                                                    st_q.ch[sel_ch].mask});
                default:     reg_rdata_o = '0;
            endcase
        end
    end

    // Bus side outputs.
    always_comb begin
        dack_o = '0;
        if (busy) dack_o[st_q.act] = 1'b1;
        hold_req_o = (st_q.fsm != S_IDLE);
        mem_rd_o   = strb && (cur.mode.kind == K_READ);
        mem_wr_o   = strb && (cur.mode.kind == K_WRITE);
        tc_o       = strb && at_tc;
        word_o     = busy && is_word;
        bus_addr_o = '0;
        if (busy) begin
            bus_addr_o = is_word ? {cur.page[PAGE_W-2:0], cur.cur_addr, 1'b0}
                                 : {cur.page, cur.cur_addr};
        end
    end

    // R3
    dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack_o));

    // R13
    no_rsv_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dack_o[RSV]);

    // R12
    fast_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fast_vec) <= MAX_FAST);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> (!(mem_rd_o && mem_wr_o) && (dack_o != '0)));

    // R7
    tc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !cur.mode.auto_init) |=> st_q.ch[$past(st_q.act)].mask);

    // R8
    single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !cur.mode.demand) |=> !hold_req_o);

endmodule

// File: tb/dma7_ctrl_tb.sv
`timescale 1ns/1ps
module dma7_ctrl_tb;

    typedef struct packed {
        logic [2:0]  ch;
        logic [4:0]  mode;
        logic [15:0] addr;
        logic [15:0] cnt;
        logic [7:0]  page;
        logic [23:0] first;
        logic        word;
        logic [7:0]  strobes;
        logic [7:0]  rels;
        logic [7:0]  dcyc;
        logic [15:0] end_addr;
        logic        end_mask;
    } vec_t;

    // mode: [4] fast, [3] reload, [2] demand, [1:0] kind
    localparam vec_t VECS [5] = '{
        '{3'd1, 5'b00001, 16'h1000, 16'd2, 8'h12, 24'h121000, 1'b0, 8'd3, 8'd3, 8'd6, 16'h1003, 1'b1},
        '{3'd6, 5'b00110, 16'h0800, 16'd3, 8'h05, 24'h0A1000, 1'b1, 8'd4, 8'd1, 8'd8, 16'h0804, 1'b1},
        '{3'd3, 5'b10100, 16'h00FE, 16'd1, 8'h00, 24'h0000FE, 1'b0, 8'd0, 8'd1, 8'd2, 16'h0100, 1'b1},
        '{3'd5, 5'b11001, 16'hFFFF, 16'd1, 8'h80, 24'h01FFFE, 1'b1, 8'd2, 8'd2, 8'd2, 16'hFFFF, 1'b0},
        '{3'd0, 5'b01110, 16'h4000, 16'd0, 8'h01, 24'h014000, 1'b0, 8'd1, 8'd1, 8'd2, 16'h4000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  dreq = '0;
    logic        hold_req;
    logic        hold_ack = 1'b1;
    logic [7:0]  dack;
    logic [23:0] bus_addr;
    logic        mem_rd, mem_wr, word, tc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dma7_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .dreq_i(dreq), .hold_req_o(hold_req), .hold_ack_i(hold_ack),
        .dack_o(dack), .bus_addr_o(bus_addr),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .word_o(word), .tc_o(tc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] ch, input logic [2:0] f, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = {ch, f}; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] ch, input logic [2:0] f, output logic [15:0] d);
        reg_addr = {ch, f};
        #1 d = reg_rdata;
    endtask

    task automatic run_vec(input vec_t v, input int k);
        int strobes = 0, rels = 0, dcyc = 0, tcs = 0, tail = 0;
        logic seen = 1'b0, prev_hold = 1'b0, fw = 1'b0;
        logic [23:0] fa = '0;
        logic [15:0] d;
        wr(v.ch, 3'd6, 16'h0000);
        wr(v.ch, 3'd4, {11'd0, v.mode});
        wr(v.ch, 3'd0, v.addr);
        wr(v.ch, 3'd1, v.cnt);
        wr(v.ch, 3'd5, {8'd0, v.page});
        dreq[v.ch] = 1'b1;
        for (int c = 0; c < 200 && tail < 5; c++) begin
            @(negedge clk);
            if (dack != 8'h00) begin
                dcyc++;
                if (!seen) begin fa = bus_addr; fw = word; seen = 1'b1; end
            end
            if (mem_rd || mem_wr) strobes++;
            if (prev_hold && !hold_req) rels++;
            prev_hold = hold_req;
            if (tc) begin tcs++; dreq = '0; end
            if (tcs > 0) tail++;
        end
        $display("vector %0d channel %0d", k, v.ch);
        chk("R4 R5 first address", {8'd0, fa}, {8'd0, v.first});
        chk("R4 R5 size flag", {31'd0, fw}, {31'd0, v.word});
        chk("R6 R10 strobe count", strobes, {24'd0, v.strobes});
        chk("R6 tc pulses", tcs, 1);
        chk("R8 R9 bus releases", rels, {24'd0, v.rels});
        chk("R11 acknowledge cycles", dcyc, {24'd0, v.dcyc});
        rd(v.ch, 3'd2, d);
        chk("R7 final current address", {16'd0, d}, {16'd0, v.end_addr});
        rd(v.ch, 3'd6, d);
        chk("R7 R6 final mask/status", {16'd0, d}, {30'd0, 1'b1, v.end_mask});
    endtask

    initial begin
        logic [15:0] d;
        int waitc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 hold_req idle", {31'd0, hold_req}, 0);
        chk("R1 dack idle", {24'd0, dack}, 0);
        rd(3'd2, 3'd6, d);
        chk("R1 ctrl masked", {16'd0, d}, 1);
        rd(3'd2, 3'd3, d);
        chk("R1 count zero", {16'd0, d}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: register map
        wr(3'd7, 3'd0, 16'hBEEF);
        rd(3'd7, 3'd0, d); chk("R2 start address", {16'd0, d}, 32'hBEEF);
        rd(3'd7, 3'd2, d); chk("R2 current follows start", {16'd0, d}, 32'hBEEF);
        wr(3'd7, 3'd2, 16'h1234);
        rd(3'd7, 3'd2, d); chk("R2 current address restore", {16'd0, d}, 32'h1234);
        rd(3'd7, 3'd0, d); chk("R2 start address kept", {16'd0, d}, 32'hBEEF);
        wr(3'd7, 3'd3, 16'h0055);
        rd(3'd7, 3'd3, d); chk("R2 current count restore", {16'd0, d}, 32'h55);
        wr(3'd7, 3'd5, 16'h003C);
        rd(3'd7, 3'd5, d); chk("R2 page", {16'd0, d}, 32'h3C);
        wr(3'd4, 3'd0, 16'h5555);
        rd(3'd4, 3'd0, d); chk("R2 slot 4 reads zero", {16'd0, d}, 0);

        // Vector table: R4..R11
        foreach (VECS[k]) run_vec(VECS[k], k);

        // R12: channels 3 and 5 hold fast; a third is refused
        wr(3'd7, 3'd4, 16'h0011);
        rd(3'd7, 3'd4, d); chk("R12 third fast refused", {16'd0, d}, 32'h01);
        wr(3'd3, 3'd4, 16'h0000);
        wr(3'd7, 3'd4, 16'h0011);
        rd(3'd7, 3'd4, d); chk("R12 fast accepted after release", {16'd0, d}, 32'h11);

        // R13: slot 4 request ignored
        dreq = 8'h10;
        waitc = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (hold_req || dack != 0) waitc++;
        end
        dreq = '0;
        chk("R13 slot 4 never served", waitc, 0);

        // R3: channels 2 and 6 together, lowest wins
        wr(3'd2, 3'd4, 16'h0005); wr(3'd2, 3'd1, 16'd0); wr(3'd2, 3'd6, 16'h0000);
        wr(3'd6, 3'd4, 16'h0005); wr(3'd6, 3'd1, 16'd0); wr(3'd6, 3'd6, 16'h0000);
        dreq = 8'h44;
        d = '0;
        for (int c = 0; c < 10 && d == 0; c++) begin
            @(negedge clk);
            d = {8'd0, dack};
        end
        chk("R3 lowest channel first", {16'd0, d}, 32'h04);
        repeat (15) @(negedge clk);
        dreq = '0;
        rd(3'd2, 3'd6, d); chk("R3 channel 2 finished", {16'd0, d}, 3);
        rd(3'd6, 3'd6, d); chk("R3 channel 6 served next", {16'd0, d}, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R6 actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule